// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves one decoded branch-class instruction per cycle. From the opcode, the 25-bit combined immediate, the parcel address read from the selected B register, the current A0 and S0 values and the address of the parcel that follows the instruction, it decides whether control transfers and, if so, to which parcel (quarter-word) address. A return jump also produces a link write carrying the follow-on address. Two-parcel branches whose unused field has a low bit set raise a range error.

All results are registered. A request presented with `req_vld` high on a rising edge appears on the response ports in the following cycle, with `rsp_vld` marking it. Register-file reads, the write of the link into its register, fetch timing and issue holds belong to the surrounding pipeline.

The immediate is laid out as a 3-bit field `i` in bits 24..22, followed by two 3-bit fields and a 16-bit field. An immediate target is always bits 21..0 of the immediate.

Top module: `brcond_unit`

## Requirements
- R1: A request accepted on a rising edge with `req_vld` high drives `rsp_vld` high for the next cycle only. While `req_vld` is low, `rsp_vld` is low and every other response port keeps its previous value.
- R2: While `rst` is high, all response ports are driven to zero.
- R3: Opcode 006 (octal) is taken with target `req_imm[21:0]`. Bit 24 of the immediate has no effect on any output.
- R4: Opcode 007 is taken with target `req_imm[21:0]`. It asserts `rsp_link_we`, and `rsp_link_addr` equals `req_next`.
- R5: Opcode 005 is taken with target `req_baddr`. It is a one-parcel instruction, so a nonzero `i` field never raises a range error for it.
- R6: Opcodes 010, 011, 012 and 013 are taken when A0 is zero, nonzero, positive and negative respectively. The sign is bit 23. Zero counts as positive.
- R7: Opcodes 014 to 017 apply the same four tests, in the same order, to S0. The sign is bit 63.
- R8: A branch that is not taken reports `req_next` as the target and does not assert `rsp_link_we`.
- R9: For opcodes 006, 007 and 010 to 017, `rsp_range_err` is set when bit 22 or bit 23 of the immediate is set. In that case the branch is not taken, no link write is made, and the target is `req_next`. Bit 24 alone raises no error.
- R10: Any other opcode is not taken, raises no error, makes no link write and reports `req_next` as the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request strobe |
| req_op | input | 7 | Branch opcode |
| req_imm | input | 25 | Combined i/j/k/m immediate |
| req_baddr | input | 22 | Parcel address read from the selected B register |
| req_a0 | input | 24 | Current A0 value |
| req_s0 | input | 64 | Current S0 value |
| req_next | input | 22 | Address of the parcel after the instruction |
| rsp_vld | output | 1 | Response valid, one cycle after the request |
| rsp_taken | output | 1 | Branch taken |
| rsp_target | output | 22 | Next parcel address to fetch |
| rsp_link_we | output | 1 | Link register write strobe |
| rsp_link_addr | output | 22 | Link value to write |
| rsp_range_err | output | 1 | Program range error |

## Verification
Every result of this block arrives exactly one rising edge after the request edge, through a single output register. The bench drives a request on a falling edge and drops `req_vld` on the next falling edge. It then compares all response ports at that same point, which is half a period after the only register stage has loaded. Hold behaviour is checked one full idle cycle later with changed inputs, to confirm that the registered values did not move.

// File: rtl/brcond_pkg.sv
package brcond_pkg;

  typedef enum logic [2:0] {
    BK_NONE,
    BK_JUMP,
    BK_CALL,
    BK_BREG,
    BK_COND
  } br_kind_e;

  // Order of the four tests follows the low two opcode bits.
  typedef enum logic [1:0] {
    TC_ZERO,
    TC_NONZERO,
    TC_POS,
    TC_NEG
  } tst_e;

  typedef struct packed {
    br_kind_e kind;
    tst_e     tst;
    logic     use_s;
    logic     two_parcel;
  } br_dec_t;

endpackage

// File: rtl/brcond_decode.sv
module brcond_decode
  import brcond_pkg::*;
#(
  parameter int OPW = 7
) (
  input  logic [OPW-1:0] op,
  output br_dec_t        dec
);

  localparam logic [OPW-1:0] OP_BREG = OPW'(5);
  localparam logic [OPW-1:0] OP_JUMP = OPW'(6);
  localparam logic [OPW-1:0] OP_CALL = OPW'(7);

  logic cond_grp;
  assign cond_grp = (op[OPW-1:4] == '0) && op[3];

  always_comb begin
    dec            = '0;
    dec.kind       = BK_NONE;
    dec.tst        = tst_e'(op[1:0]);
    dec.use_s      = op[2];
    if (op == OP_BREG) begin
      dec.kind = BK_BREG;
    end else if (op == OP_JUMP) begin
      dec.kind       = BK_JUMP;
      dec.two_parcel = 1'b1;
    end else if (op == OP_CALL) begin
      dec.kind       = BK_CALL;
      dec.two_parcel = 1'b1;
    end else if (cond_grp) begin
      dec.kind       = BK_COND;
      dec.two_parcel = 1'b1;
    end
  end

endmodule

// File: rtl/brcond_test.sv
module brcond_test
  import brcond_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [W-1:0] val,
  input  tst_e         tst,
  output logic         hit
);

  logic is_zero;
  logic is_neg;

  assign is_zero = (val == '0);
  assign is_neg  = val[W-1];

  always_comb begin
    unique case (tst)
      TC_ZERO:    hit = is_zero;
      TC_NONZERO: hit = !is_zero;
      TC_POS:     hit = !is_neg;
      TC_NEG:     hit = is_neg;
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/brcond_select.sv
module brcond_select #(
  parameter int PW = 22
) (
  input  logic          taken,
  input  logic          use_b,
  input  logic [PW-1:0] imm_tgt,
  input  logic [PW-1:0] b_tgt,
  input  logic [PW-1:0] next_addr,
  output logic [PW-1:0] target
);

  always_comb begin
    if (!taken)     target = next_addr;
    else if (use_b) target = b_tgt;
    else            target = imm_tgt;
  end

endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
  import brcond_pkg::*;
#(
  parameter int OPW = 7,
  parameter int IFW = 3,
  parameter int MW  = 16,
  parameter int PW  = 22,
  parameter int AW  = 24,
  parameter int SW  = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_vld,
  input  logic [OPW-1:0]           req_op,
  input  logic [3*IFW+MW-1:0]      req_imm,
  input  logic [PW-1:0]            req_baddr,
  input  logic [AW-1:0]            req_a0,
  input  logic [SW-1:0]            req_s0,
  input  logic [PW-1:0]            req_next,
  output logic                     rsp_vld,
  output logic                     rsp_taken,
  output logic [PW-1:0]            rsp_target,
  output logic                     rsp_link_we,
  output logic [PW-1:0]            rsp_link_addr,
  output logic                     rsp_range_err
);

  localparam int IMMW  = 3*IFW + MW;
  localparam int I_LO  = IMMW - IFW;

  br_dec_t       dec;
  logic          a_hit, s_hit, cond_hit;
  logic          err_c, taken_c, link_c, fixed_c;
  logic [PW-1:0] tgt_c;
  logic          unused_ihi;

  // The top bit of the i field plays no part in any result.
  assign unused_ihi = req_imm[IMMW-1];

  brcond_decode #(.OPW(OPW)) u_dec (
    .op  (req_op),
    .dec (dec)
  );

  brcond_test #(.W(AW)) u_test_a (
    .val (req_a0),
    .tst (dec.tst),
    .hit (a_hit)
  );

  brcond_test #(.W(SW)) u_test_s (
    .val (req_s0),
    .tst (dec.tst),
    .hit (s_hit)
  );

  assign cond_hit = dec.use_s ? s_hit : a_hit;
  assign err_c    = dec.two_parcel && (req_imm[I_LO+1:I_LO] != 2'b00);
  assign fixed_c  = (dec.kind == BK_JUMP) || (dec.kind == BK_CALL) ||
                    (dec.kind == BK_BREG);
  assign taken_c  = !err_c && (fixed_c || ((dec.kind == BK_COND) && cond_hit));
  assign link_c   = !err_c && (dec.kind == BK_CALL);

  brcond_select #(.PW(PW)) u_sel (
    .taken     (taken_c),
    .use_b     (dec.kind == BK_BREG),
    .imm_tgt   (req_imm[PW-1:0]),
    .b_tgt     (req_baddr),
    .next_addr (req_next),
    .target    (tgt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld       <= 1'b0;
      rsp_taken     <= 1'b0;
      rsp_target    <= '0;
      rsp_link_we   <= 1'b0;
      rsp_link_addr <= '0;
      rsp_range_err <= 1'b0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_taken     <= taken_c;
        rsp_target    <= tgt_c;
        rsp_link_we   <= link_c;
        rsp_link_addr <= link_c ? req_next : '0;
        rsp_range_err <= err_c;
      end
    end
  end

  p_vld_next_r1: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_vld);

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> (!rsp_vld && $stable(rsp_target) && $stable(rsp_taken) &&
                  $stable(rsp_range_err)));

  p_call_link_r4: assert property (@(posedge clk) disable iff (rst)
    (req_vld && dec.kind == BK_CALL && !err_c) |=>
      (rsp_link_we && rsp_link_addr == $past(req_next)));

  p_breg_no_err_r5: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_op == OPW'(5)) |=> !rsp_range_err);

  p_err_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_range_err |-> (!rsp_taken && !rsp_link_we));

  p_link_needs_taken_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_link_we |-> rsp_taken);

  p_zero_is_pos_r6: assert property (@(posedge clk) disable iff (rst)
    (req_vld && dec.kind == BK_COND && !err_c && !dec.use_s &&
     req_a0 == '0 && dec.tst == TC_POS) |=> rsp_taken);

endmodule

// File: tb/brcond_unit_tb_top.sv
`timescale 1ns/1ps
module brcond_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_vld;
  logic [6:0]  req_op;
  logic [24:0] req_imm;
  logic [21:0] req_baddr;
  logic [23:0] req_a0;
  logic [63:0] req_s0;
  logic [21:0] req_next;
  logic        rsp_vld, rsp_taken, rsp_link_we, rsp_range_err;
  logic [21:0] rsp_target, rsp_link_addr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  brcond_unit dut_i (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_op(req_op),
    .req_imm(req_imm), .req_baddr(req_baddr), .req_a0(req_a0),
    .req_s0(req_s0), .req_next(req_next), .rsp_vld(rsp_vld),
    .rsp_taken(rsp_taken), .rsp_target(rsp_target),
    .rsp_link_we(rsp_link_we), .rsp_link_addr(rsp_link_addr),
    .rsp_range_err(rsp_range_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [24:0] mk(input logic [2:0] i, input logic [21:0] t);
    return {i, t};
  endfunction

  // Drive at a falling edge, let one rising edge register it, check at the next falling edge.
  task automatic run(input string tag, input logic [6:0] op, input logic [24:0] imm,
                     input logic [21:0] b, input logic [23:0] a0, input logic [63:0] s0,
                     input logic [21:0] nx, input bit e_tk, input logic [21:0] e_tg,
                     input bit e_lw, input bit e_er);
    @(negedge clk);
    req_vld = 1'b1; req_op = op; req_imm = imm; req_baddr = b;
    req_a0 = a0; req_s0 = s0; req_next = nx;
    @(negedge clk);
    req_vld = 1'b0;
    chk(rsp_vld == 1'b1, {tag, " R1 vld"}, 64'(rsp_vld), 64'd1);
    chk(rsp_taken == e_tk, {tag, " taken"}, 64'(rsp_taken), 64'(e_tk));
    chk(rsp_target == e_tg, {tag, " target"}, 64'(rsp_target), 64'(e_tg));
    chk(rsp_link_we == e_lw, {tag, " link_we"}, 64'(rsp_link_we), 64'(e_lw));
    chk(rsp_range_err == e_er, {tag, " range_err"}, 64'(rsp_range_err), 64'(e_er));
    if (e_lw)
      chk(rsp_link_addr == nx, {tag, " link_addr"}, 64'(rsp_link_addr), 64'(nx));
  endtask

  task automatic t_reset;
    rst = 1'b1; req_vld = 1'b0; req_op = '0; req_imm = '0; req_baddr = '0;
    req_a0 = '0; req_s0 = '0; req_next = '0;
    repeat (3) @(negedge clk);
    chk(!rsp_vld && !rsp_taken && !rsp_link_we && !rsp_range_err &&
        rsp_target == 0 && rsp_link_addr == 0, "R2 reset state",
        {rsp_vld, rsp_taken, rsp_link_we, rsp_range_err, rsp_target, rsp_link_addr}, 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_jump;
    run("R3 jump", 7'o06, mk(3'b000, 22'h12345), 22'h3, 24'h0, 64'h0, 22'h100,
        1, 22'h12345, 0, 0);
    run("R3 jump top bit ignored", 7'o06, mk(3'b100, 22'h3ABCDE), 22'h3, 24'h1, 64'h0,
        22'h200, 1, 22'h3ABCDE, 0, 0);
  endtask

  task automatic t_call;
    run("R4 call", 7'o07, mk(3'b000, 22'h00ABC), 22'h5, 24'h0, 64'h0, 22'h001000,
        1, 22'h00ABC, 1, 0);
  endtask

  task automatic t_breg;
    run("R5 breg", 7'o05, mk(3'b011, 22'h1), 22'h3FFFF0, 24'h0, 64'h0, 22'h44,
        1, 22'h3FFFF0, 0, 0);
  endtask

  task automatic t_a0;
    run("R6 a0=0 zero", 7'o10, mk(0, 22'h111), 0, 24'h0, 64'h0, 22'h9, 1, 22'h111, 0, 0);
    run("R6 a0=0 nonzero", 7'o11, mk(0, 22'h111), 0, 24'h0, 64'h0, 22'h9, 0, 22'h9, 0, 0);
    run("R6 a0=0 positive", 7'o12, mk(0, 22'h222), 0, 24'h0, 64'h0, 22'h9, 1, 22'h222, 0, 0);
    run("R6 a0=0 negative", 7'o13, mk(0, 22'h222), 0, 24'h0, 64'h0, 22'h9, 0, 22'h9, 0, 0);
    run("R6 a0 neg zero", 7'o10, mk(0, 22'h333), 0, 24'h800000, 64'h0, 22'hA, 0, 22'hA, 0, 0);
    run("R6 a0 neg nonzero", 7'o11, mk(0, 22'h333), 0, 24'h800000, 64'h0, 22'hA, 1, 22'h333, 0, 0);
    run("R6 a0 neg positive", 7'o12, mk(0, 22'h333), 0, 24'h800000, 64'h0, 22'hA, 0, 22'hA, 0, 0);
    run("R6 a0 neg negative", 7'o13, mk(0, 22'h333), 0, 24'h800000, 64'h0, 22'hA, 1, 22'h333, 0, 0);
    run("R6 a0=1 positive", 7'o12, mk(0, 22'h444), 0, 24'h1, 64'h0, 22'hB, 1, 22'h444, 0, 0);
  endtask

  task automatic t_s0;
    run("R7 s0 neg negative", 7'o17, mk(0, 22'h555), 0, 24'h0, 64'h8000_0000_0000_0000,
        22'hC, 1, 22'h555, 0, 0);
    run("R7 s0 neg positive", 7'o16, mk(0, 22'h555), 0, 24'h0, 64'h8000_0000_0000_0000,
        22'hC, 0, 22'hC, 0, 0);
    run("R7 s0=0 zero", 7'o14, mk(0, 22'h666), 0, 24'h1, 64'h0, 22'hD, 1, 22'h666, 0, 0);
    run("R7 s0=0 positive", 7'o16, mk(0, 22'h666), 0, 24'h1, 64'h0, 22'hD, 1, 22'h666, 0, 0);
    run("R7 s0 high word nonzero", 7'o15, mk(0, 22'h777), 0, 24'h0, 64'h1_0000_0000,
        22'hE, 1, 22'h777, 0, 0);
    run("R7 s0 high word zero-test", 7'o14, mk(0, 22'h777), 0, 24'h0, 64'h1_0000_0000,
        22'hE, 0, 22'hE, 0, 0);
  endtask

  task automatic t_err;
    run("R9 jump i=001", 7'o06, mk(3'b001, 22'h123), 0, 0, 0, 22'h50, 0, 22'h50, 0, 1);
    run("R9 call i=010", 7'o07, mk(3'b010, 22'h123), 0, 0, 0, 22'h51, 0, 22'h51, 0, 1);
    run("R9 cond i=011", 7'o10, mk(3'b011, 22'h123), 0, 24'h0, 0, 22'h52, 0, 22'h52, 0, 1);
    run("R9 cond i=100 no err", 7'o14, mk(3'b100, 22'h124), 0, 0, 64'h0, 22'h53, 1, 22'h124, 0, 0);
  endtask

  task automatic t_other;
    run("R10 op 022", 7'o22, mk(0, 22'h99), 22'h7, 0, 0, 22'h60, 0, 22'h60, 0, 0);
    run("R10 op 000", 7'o00, mk(3'b011, 22'h99), 22'h7, 0, 0, 22'h61, 0, 22'h61, 0, 0);
    run("R8 not taken no link", 7'o11, mk(0, 22'h98), 0, 24'h0, 0, 22'h62, 0, 22'h62, 0, 0);
  endtask

  task automatic t_hold;
    run("R1 setup", 7'o07, mk(0, 22'h2468), 0, 0, 0, 22'h70, 1, 22'h2468, 1, 0);
    @(negedge clk);
    req_op = 7'o06; req_imm = mk(3'b001, 22'h1357); req_next = 22'h71;
    @(negedge clk);
    chk(rsp_vld == 1'b0, "R1 idle vld", 64'(rsp_vld), 64'd0);
    chk(rsp_target == 22'h2468, "R1 hold target", 64'(rsp_target), 64'h2468);
    chk(rsp_taken == 1'b1 && rsp_range_err == 1'b0, "R1 hold flags",
        {rsp_taken, rsp_range_err}, 64'd2);
  endtask

  initial begin
    t_reset();
    t_jump();
    t_call();
    t_breg();
    t_a0();
    t_s0();
    t_err();
    t_other();
    t_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule